// File: doc/BRIEF.md
# Shared Test Access Mechanism Controller

This block is the one chip-level controller that carries test data between the tester-facing test access bus and several wrapped cores. A parallel input bus comes from the tester. A parallel output bus goes back to it. Every core has its own serial-in and serial-out bundle, each as wide as the test bus, and its own shift, capture and update strobes. The controller holds a small configuration, and that configuration chooses one of three routings. In single-core mode the whole bus reaches one core, so cores are tested one after another. In chained mode the selected cores are joined, in ascending core order, into one long path from the input bus to the output bus. In split mode every core owns a fixed lane of the bus, and all cores are tested at the same time.

The tester loads the configuration serially through the same pins it uses for test data. It raises the configure strobe, shifts in the new bits with the shift strobe, and then pulses the update strobe. The new routing applies only from that update onward. While the configure strobe is high, no core sees any strobe. Outside configuration, the strobes reach only the cores that are active in the current routing.

Top module: `tam_access_ctrl`

## Requirements
- R1: A 6-bit staging register shifts right by one, with `cfg_si` entering at bit 5, on every clock where `cfg_en` and `shift_in` are both high, so bits are sent LSB first. The live configuration copies the staging register on a clock where `cfg_en` and `update_in` are high and `shift_in` is low. In the live configuration, bits [1:0] are the mode (00 single-core, 01 chained, 10 split, 11 idle) and bits [5:2] are the selection field. After reset, the live configuration is mode 00 with selection 0.
- R2: In mode 00 with a selection below 4, the core with that index receives `tam_in` on its serial-in bundle, and `tam_out` equals that core's serial-out bundle.
- R3: In mode 00 with a selection of 4 or more, `tam_out` is all zero, every serial-in bundle is zero and no core strobe is raised.
- R4: In mode 01 the selection is a core mask (bit k selects core k). The path starts at `tam_in`, passes through each selected core in ascending index order, and ends at `tam_out`. Each unselected core is bypassed without delay, so a mask of zero gives `tam_out` = `tam_in`.
- R5: In mode 10 all cores are active and the selection is ignored. Core k takes `tam_in[2k+1:2k]` on bits [1:0] of its serial-in bundle, with zeros above, and drives `tam_out[2k+1:2k]` from bits [1:0] of its serial-out bundle.
- R6: In mode 11 no core is active, `tam_out` is zero and every serial-in bundle is zero.
- R7: With `cfg_en` low, each core's shift, capture and update strobes follow `shift_in`, `capture_in` and `update_in` if the core is active in the current mode, and stay low otherwise.
- R8: While `cfg_en` is high, every core strobe is low.
- R9: Shifting the staging register does not change the routing. An update that arrives while `shift_in` is high commits nothing, so the previous routing stays in force.
- R10: The serial-in bundle of every inactive core is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configure strobe: steers shift and update to the configuration |
| cfg_si | input | 1 | Serial configuration data |
| shift_in | input | 1 | Shift strobe from the tester |
| capture_in | input | 1 | Capture strobe from the tester |
| update_in | input | 1 | Update strobe from the tester |
| tam_in | input | 8 | Test bus from the tester |
| tam_out | output | 8 | Test bus back to the tester |
| core_si | output | 32 | Serial-in bundles, core k at bits [8k+7:8k] |
| core_so | input | 32 | Serial-out bundles, core k at bits [8k+7:8k] |
| core_shift | output | 4 | Per-core shift strobe |
| core_capture | output | 4 | Per-core capture strobe |
| core_update | output | 4 | Per-core update strobe |

## Verification
The bench drives a fresh random value onto every core's serial-out bundle and onto the test bus each cycle, so a wrong source core or a wrong lane always shows up as a data mismatch. In single-core mode it selects several in-range indices and one out-of-range index. The in-range cases catch an off-by-one decode, and the out-of-range case catches output that is not zeroed. In chained mode it uses a sparse mask, the full mask and an empty mask. These tell a wrong hop order or a missing bypass apart from plain pass-through. Split mode is run with a non-zero selection to show that the field is ignored. Idle mode and an update raised together with shift test the hold rules.

// File: rtl/tam_pkg.sv
package tam_pkg;
    typedef enum logic [1:0] {
        TM_SINGLE = 2'b00,
        TM_CHAIN  = 2'b01,
        TM_SPLIT  = 2'b10,
        TM_IDLE   = 2'b11
    } tam_mode_e;
endpackage

// File: rtl/tam_cfg_reg.sv
module tam_cfg_reg
    import tam_pkg::*;
#(
    parameter int SEL_W = 4,
    localparam int CFG_W = SEL_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_si,
    input  logic             shift_in,
    input  logic             update_in,
    output logic [CFG_W-1:0] stage,
    output tam_mode_e        live_mode,
    output logic [SEL_W-1:0] live_sel
);
    typedef struct packed {
        logic [CFG_W-1:0] stage;
        logic [CFG_W-1:0] live;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // commit uses the staging value as it was before this edge
        if (cfg_en && update_in && !shift_in) begin
            st_d.live = st_q.stage;
        end
        if (cfg_en && shift_in) begin
            st_d.stage = {cfg_si, st_q.stage[CFG_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stage     = st_q.stage;
    assign live_mode = tam_mode_e'(st_q.live[1:0]);
    assign live_sel  = st_q.live[CFG_W-1:2];
endmodule

// File: rtl/tam_core_enable.sv
module tam_core_enable
    import tam_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int SEL_W     = 4
) (
    input  tam_mode_e            mode,
    input  logic [SEL_W-1:0]     sel,
    output logic [NUM_CORES-1:0] active
);
    for (genvar k = 0; k < NUM_CORES; k++) begin : g_core
        always_comb begin
            unique case (mode)
                TM_SINGLE: active[k] = (sel == SEL_W'(k));
                TM_CHAIN:  active[k] = sel[k];
                TM_SPLIT:  active[k] = 1'b1;
                default:   active[k] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/tam_router.sv
module tam_router
    import tam_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int TAM_W     = 8,
    localparam int LANE_W   = TAM_W / NUM_CORES,
    localparam int FLAT_W   = NUM_CORES * TAM_W
) (
    input  tam_mode_e            mode,
    input  logic [NUM_CORES-1:0] active,
    input  logic [TAM_W-1:0]     tam_in,
    input  logic [FLAT_W-1:0]    core_so,
    output logic [FLAT_W-1:0]    core_si,
    output logic [TAM_W-1:0]     tam_out
);
    logic [TAM_W-1:0]  hop;
    logic [FLAT_W-1:0] split_si;
    logic [TAM_W-1:0]  split_out;

    // fixed lane wiring for split mode, one slice per core
    for (genvar k = 0; k < NUM_CORES; k++) begin : g_lane
        if (TAM_W > LANE_W) begin : g_pad
            assign split_si[k*TAM_W+LANE_W +: TAM_W-LANE_W] = '0;
        end
        assign split_si[k*TAM_W +: LANE_W]  = tam_in[k*LANE_W +: LANE_W];
        assign split_out[k*LANE_W +: LANE_W] = core_so[k*TAM_W +: LANE_W];
    end

    always_comb begin
        core_si = '0;
        tam_out = '0;
        hop     = tam_in;
        unique case (mode)
            TM_SINGLE: begin
                for (int k = 0; k < NUM_CORES; k++) begin
                    if (active[k]) begin
                        core_si[k*TAM_W +: TAM_W] = tam_in;
                        tam_out = core_so[k*TAM_W +: TAM_W];
                    end
                end
            end
            TM_CHAIN: begin
                for (int k = 0; k < NUM_CORES; k++) begin
                    if (active[k]) begin
                        core_si[k*TAM_W +: TAM_W] = hop;
                        hop = core_so[k*TAM_W +: TAM_W];
                    end
                end
                tam_out = hop;
            end
            TM_SPLIT: begin
                core_si = split_si;
                tam_out = split_out;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/tam_access_ctrl.sv
module tam_access_ctrl
    import tam_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int TAM_W     = 8,
    localparam int SEL_W    = NUM_CORES,
    localparam int CFG_W    = SEL_W + 2,
    localparam int FLAT_W   = NUM_CORES * TAM_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_en,
    input  logic                 cfg_si,
    input  logic                 shift_in,
    input  logic                 capture_in,
    input  logic                 update_in,
    input  logic [TAM_W-1:0]     tam_in,
    output logic [TAM_W-1:0]     tam_out,
    output logic [FLAT_W-1:0]    core_si,
    input  logic [FLAT_W-1:0]    core_so,
    output logic [NUM_CORES-1:0] core_shift,
    output logic [NUM_CORES-1:0] core_capture,
    output logic [NUM_CORES-1:0] core_update
);
    tam_mode_e            live_mode;
    logic [SEL_W-1:0]     live_sel;
    logic [CFG_W-1:0]     stage_vec;
    logic [NUM_CORES-1:0] active;
    logic                 pass_ok;

    tam_cfg_reg #(.SEL_W(SEL_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_en   (cfg_en),
        .cfg_si   (cfg_si),
        .shift_in (shift_in),
        .update_in(update_in),
        .stage    (stage_vec),
        .live_mode(live_mode),
        .live_sel (live_sel)
    );

    tam_core_enable #(.NUM_CORES(NUM_CORES), .SEL_W(SEL_W)) u_en (
        .mode  (live_mode),
        .sel   (live_sel),
        .active(active)
    );

    tam_router #(.NUM_CORES(NUM_CORES), .TAM_W(TAM_W)) u_route (
        .mode   (live_mode),
        .active (active),
        .tam_in (tam_in),
        .core_so(core_so),
        .core_si(core_si),
        .tam_out(tam_out)
    );

    // strobes reach wrappers only outside configuration
    assign pass_ok      = !cfg_en;
    assign core_shift   = active & {NUM_CORES{shift_in   & pass_ok}};
    assign core_capture = active & {NUM_CORES{capture_in & pass_ok}};
    assign core_update  = active & {NUM_CORES{update_in  & pass_ok}};
endmodule

// File: rtl/tam_access_ctrl_chk.sv
module tam_access_ctrl_chk
    import tam_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int TAM_W     = 8,
    localparam int SEL_W    = NUM_CORES,
    localparam int CFG_W    = SEL_W + 2,
    localparam int FLAT_W   = NUM_CORES * TAM_W
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_en,
    input logic                 shift_in,
    input logic                 update_in,
    input tam_mode_e            live_mode,
    input logic [SEL_W-1:0]     live_sel,
    input logic [CFG_W-1:0]     stage_vec,
    input logic [TAM_W-1:0]     tam_out,
    input logic [FLAT_W-1:0]    core_si,
    input logic [NUM_CORES-1:0] core_shift,
    input logic [NUM_CORES-1:0] core_capture,
    input logic [NUM_CORES-1:0] core_update
);
    localparam logic [SEL_W-1:0] NC_SEL = SEL_W'(NUM_CORES);

    p_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && update_in && !shift_in) |=> ({live_sel, live_mode} == $past(stage_vec)));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_en && update_in && !shift_in) |=> $stable({live_sel, live_mode}));

    p_quiet_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (core_shift == '0 && core_capture == '0 && core_update == '0));

    p_single_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_mode == TM_SINGLE) |-> $onehot0(core_shift | core_capture | core_update));

    p_oor_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_mode == TM_SINGLE && live_sel >= NC_SEL) |-> (tam_out == '0 && core_si == '0));

    p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (live_mode == TM_IDLE) |-> (tam_out == '0 && core_si == '0 && core_shift == '0));

    p_split_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (live_mode == TM_SPLIT && !cfg_en) |-> (core_shift == {NUM_CORES{shift_in}}));
endmodule

bind tam_access_ctrl tam_access_ctrl_chk #(.NUM_CORES(NUM_CORES), .TAM_W(TAM_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_en      (cfg_en),
    .shift_in    (shift_in),
    .update_in   (update_in),
    .live_mode   (live_mode),
    .live_sel    (live_sel),
    .stage_vec   (stage_vec),
    .tam_out     (tam_out),
    .core_si     (core_si),
    .core_shift  (core_shift),
    .core_capture(core_capture),
    .core_update (core_update)
);

// File: tb/tb_tam_access_ctrl.sv
module tb_tam_access_ctrl;
    localparam int NC = 4;
    localparam int TW = 8;
    localparam int LN = TW / NC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0, cfg_si = 1'b0;
    logic sh = 1'b0, ca = 1'b0, up = 1'b0;
    logic [TW-1:0] tam_in = '0;
    logic [TW-1:0] tam_out;
    logic [NC*TW-1:0] core_si, core_so;
    logic [NC-1:0] c_sh, c_ca, c_up;
    logic [TW-1:0] so_v [NC];

    int total = 0, bad = 0;
    bit done = 0;

    // behavioural model state
    int m_stage = 0;
    int m_live  = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int k = 0; k < NC; k++) core_so[k*TW +: TW] = so_v[k];
    end

    tam_access_ctrl #(.NUM_CORES(NC), .TAM_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_si(cfg_si),
        .shift_in(sh), .capture_in(ca), .update_in(up),
        .tam_in(tam_in), .tam_out(tam_out), .core_si(core_si), .core_so(core_so),
        .core_shift(c_sh), .core_capture(c_ca), .core_update(c_up)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_stage = 0;
            m_live  = 0;
        end else begin
            if (cfg_en && up && !sh) m_live = m_stage;
            if (cfg_en && sh) m_stage = (m_stage >> 1) | (int'(cfg_si) << 5);
        end
    end

    function automatic void model_out(output logic [TW-1:0] eo,
                                      output logic [NC*TW-1:0] esi,
                                      output logic [NC-1:0] eact);
        int mode = m_live & 3;
        int sel  = m_live >> 2;
        logic [TW-1:0] cur = tam_in;
        eo = '0; esi = '0; eact = '0;
        if (mode == 0) begin
            if (sel < NC) begin
                eact[sel] = 1'b1;
                esi[sel*TW +: TW] = tam_in;
                eo = so_v[sel];
            end
        end else if (mode == 1) begin
            for (int k = 0; k < NC; k++) begin
                if (((sel >> k) & 1) == 1) begin
                    eact[k] = 1'b1;
                    esi[k*TW +: TW] = cur;
                    cur = so_v[k];
                end
            end
            eo = cur;
        end else if (mode == 2) begin
            eact = '1;
            for (int k = 0; k < NC; k++) begin
                esi[k*TW +: LN] = tam_in[k*LN +: LN];
                eo[k*LN +: LN]  = so_v[k][LN-1:0];
            end
        end
    endfunction

    function automatic string out_tag();
        int mode = m_live & 3;
        if (mode == 0) return ((m_live >> 2) < NC) ? "R2" : "R3";
        if (mode == 1) return "R4";
        if (mode == 2) return "R5";
        return "R6";
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string force_tag);
        logic [TW-1:0] eo;
        logic [NC*TW-1:0] esi;
        logic [NC-1:0] eact, es, ec, eu;
        string t;
        model_out(eo, esi, eact);
        t = (force_tag != "") ? force_tag : out_tag();
        chk(tam_out === eo, t, "tam_out", 64'(tam_out), 64'(eo));
        chk(core_si === esi, "R10", "core_si", 64'(core_si), 64'(esi));
        es = (cfg_en || !sh) ? '0 : eact;
        ec = (cfg_en || !ca) ? '0 : eact;
        eu = (cfg_en || !up) ? '0 : eact;
        chk({c_sh, c_ca, c_up} === {es, ec, eu}, cfg_en ? "R8" : "R7", "strobes",
            64'({c_sh, c_ca, c_up}), 64'({es, ec, eu}));
    endtask

    task automatic cyc(input logic ce, input logic s, input logic c,
                       input logic u, input logic d);
        @(negedge clk);
        if (rst_n) compare("");
        cfg_en = ce; sh = s; ca = c; up = u; cfg_si = d;
        tam_in = TW'($urandom);
        for (int k = 0; k < NC; k++) so_v[k] = TW'($urandom);
    endtask

    task automatic load(input int mode, input int sel, input bit commit);
        int v = (sel << 2) | mode;
        for (int b = 0; b < 6; b++) cyc(1'b1, 1'b1, 1'b0, 1'b0, logic'((v >> b) & 1));
        if (commit) cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic traffic(input int n);
        for (int i = 0; i < n; i++)
            cyc(1'b0, logic'($urandom & 1), logic'($urandom & 1), logic'($urandom & 1), 1'b0);
    endtask

    initial begin
        for (int k = 0; k < NC; k++) so_v[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        // R1: reset state is single-core mode on core 0
        @(negedge clk);
        chk(tam_out === so_v[0], "R1", "reset routing", 64'(tam_out), 64'(so_v[0]));
        traffic(10);
        load(0, 2, 1); traffic(20);
        load(0, 0, 1); traffic(10);
        load(0, 3, 1); traffic(10);
        load(0, 9, 1); traffic(15);            // out-of-range index, R3
        load(1, 4'b1011, 1); traffic(20);      // sparse chain, R4
        load(1, 4'b1111, 1); traffic(15);
        load(1, 0, 1); traffic(10);
        load(2, 5, 1); traffic(20);            // split, selection ignored, R5
        load(3, 0, 1); traffic(10);            // idle, R6
        // R9: staging shift plus update-with-shift must not change routing
        load(0, 1, 1); traffic(5);
        load(2, 0, 0);
        cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk(tam_out === so_v[1], "R9", "routing held", 64'(tam_out), 64'(so_v[1]));
        traffic(10);
        // R1: a clean commit of the shifted value takes effect
        load(1, 4'b0110, 1);
        @(negedge clk);
        compare("R1");
        traffic(10);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule